// File: doc/BRIEF.md
# Bit-Serial Incrementer

This block adds one to an unsigned binary number that arrives one bit per clock, least significant bit first. It emits one result bit on each accepted input bit, in the same order, through a combinational path from the input bit and a single stored carry bit. No extra pipeline stage is added. The stored bit is the whole state of the machine. A value of 1 means a carry is still pending, and a value of 0 means the carry has been used up and the remaining bits pass through unchanged.

A qualifier input marks the clocks that carry a bit; the carry is held on the other clocks. A start marker forces a pending carry for the bit it arrives with. An end marker reports overflow when the last bit produces a carry out, which happens only when every bit of the number was 1. After the end bit the machine re-arms itself. Numbers can therefore be streamed back to back, with or without start markers.

Top module: `serial_incrementer`

## Requirements
- R1: A synchronous active-high reset puts the machine in the carry state, so the first accepted bit after reset is incremented even without a start marker.
- R2: In the carry state an input 1 produces output 0, and the machine stays in the carry state.
- R3: In the carry state an input 0 produces output 1, and the machine moves to the no-carry state.
- R4: In the no-carry state the output bit equals the input bit, and the state does not change.
- R5: A start marker that comes with a valid bit makes that bit behave as in the carry state, whatever the stored state.
- R6: On a clock where the valid input is low, the stored state is unchanged, and the result bit and overflow flag are 0 whatever the other inputs are.
- R7: The output-valid signal equals the input valid in the same cycle, so the result bit has no added latency.
- R8: The overflow flag is 1 exactly on a valid end-marked bit whose carry out is 1, that is, when the input bit is 1 and the machine is in the carry state or a start marker is present.
- R9: After a valid end-marked bit the machine returns to the carry state, so the next number is incremented without a start marker.
- R10: The input bits 1,1,0,1 (the value 11) with start and end markers give the output 0,0,1,1 (the value 12), with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A bit is presented this cycle |
| in_bit | input | 1 | Operand bit, least significant bit first |
| in_sop | input | 1 | First bit of a number |
| in_eop | input | 1 | Last bit of a number |
| out_valid | output | 1 | Result bit is valid this cycle |
| out_bit | output | 1 | Result bit, least significant bit first |
| out_ovf | output | 1 | Carry out of the last bit; the number was all ones |

## Verification
The bench goes after the cases where the carry state is easy to mishandle. An all-ones number must wrap to zero and raise overflow; a design that drops the carry out would leave the flag low. Idle gaps inside a number test whether a design advances its state on clocks with no valid bit, which would corrupt the upper result bits. Start markers that arrive while the stored state is no-carry, and numbers that follow an end bit with no start marker, test whether the machine re-arms. A design that fails to re-arm increments only the first number of a stream.

// File: rtl/serial_inc_pkg.sv
package serial_inc_pkg;

  typedef enum logic {
    ST_NOCARRY = 1'b0,
    ST_CARRY   = 1'b1
  } carry_state_t;

  localparam carry_state_t ARMED_STATE = ST_CARRY;

endpackage

// File: rtl/serial_inc_cell.sv
module serial_inc_cell (
  input  logic a_bit,
  input  logic cin,
  output logic sum,
  output logic cout
);

  // Half adder: adding a pending carry of one to a single bit
  always_comb begin
    sum  = a_bit ^ cin;
    cout = a_bit & cin;
  end

endmodule

// File: rtl/serial_inc_state.sv
module serial_inc_state
  import serial_inc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         rearm,
  input  logic         carry_in,
  output carry_state_t state
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ARMED_STATE;
    end else if (step) begin
      if (rearm) state <= ARMED_STATE;
      else       state <= carry_in ? ST_CARRY : ST_NOCARRY;
    end
  end

endmodule

// File: rtl/serial_incrementer.sv
module serial_incrementer
  import serial_inc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_sop,
  input  logic in_eop,
  output logic out_valid,
  output logic out_bit,
  output logic out_ovf
);

  carry_state_t cur_state;
  logic         eff_carry;
  logic         cell_sum;
  logic         cell_cout;

  // A start marker forces the pending carry for its own bit
  always_comb eff_carry = in_sop | (cur_state == ST_CARRY);

  serial_inc_cell u_cell (
    .a_bit (in_bit),
    .cin   (eff_carry),
    .sum   (cell_sum),
    .cout  (cell_cout)
  );

  serial_inc_state u_state (
    .clk      (clk),
    .rst      (rst),
    .step     (in_valid),
    .rearm    (in_eop),
    .carry_in (cell_cout),
    .state    (cur_state)
  );

  always_comb begin
    out_valid = in_valid;
    out_bit   = in_valid & cell_sum;
    out_ovf   = in_valid & in_eop & cell_cout;
  end

endmodule

// File: rtl/serial_incrementer_sva.sv
module serial_incrementer_sva
  import serial_inc_pkg::*;
(
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_bit,
  input logic         in_sop,
  input logic         in_eop,
  input logic         out_valid,
  input logic         out_bit,
  input logic         out_ovf,
  input carry_state_t cur_state
);

  AST_RESET_ARMS: assert property (@(posedge clk)
    rst |=> cur_state == ST_CARRY); // R1

  AST_ONE_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_eop && cur_state == ST_CARRY && in_bit) |=> cur_state == ST_CARRY); // R2

  AST_ZERO_ENDS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_eop && cur_state == ST_CARRY && !in_bit) |-> out_bit); // R3

  AST_ZERO_DROPS_STATE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_eop && !in_sop && cur_state == ST_CARRY && !in_bit) |=> cur_state == ST_NOCARRY); // R3

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sop && cur_state == ST_NOCARRY) |-> out_bit == in_bit); // R4

  AST_SOP_FORCES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop) |-> out_bit == !in_bit); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cur_state)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (!out_bit && !out_ovf)); // R6

  AST_VALID_MIRROR: assert property (@(posedge clk) disable iff (rst)
    out_valid == in_valid); // R7

  AST_OVF_ONLY_END: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (in_valid && in_eop && in_bit && !out_bit)); // R8

  AST_EOP_REARMS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eop) |=> cur_state == ST_CARRY); // R9

endmodule

bind serial_incrementer serial_incrementer_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_bit    (in_bit),
  .in_sop    (in_sop),
  .in_eop    (in_eop),
  .out_valid (out_valid),
  .out_bit   (out_bit),
  .out_ovf   (out_ovf),
  .cur_state (cur_state)
);

// File: tb/tb_serial_incrementer.sv
module tb_serial_incrementer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_sop = 1'b0;
  logic in_eop = 1'b0;
  logic out_valid, out_bit, out_ovf;

  int checks = 0;
  int errors = 0;
  logic model_carry = 1'b1;
  bit done = 1'b0;

  typedef struct {
    logic  exp_bit;
    logic  exp_ovf;
    string tag;
  } item_t;

  item_t sb_q[$];

  always #2 clk = ~clk;

  serial_incrementer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_bit(out_bit), .out_ovf(out_ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: present one bit, push expected result from the requirement model
  task automatic send(input logic b, input logic s, input logic e, input string tag);
    item_t it;
    logic c, co;
    @(posedge clk); #1;
    in_valid = 1'b1; in_bit = b; in_sop = s; in_eop = e;
    c  = s | model_carry;
    co = b & c;
    it.exp_bit = b ^ c;
    it.exp_ovf = e & co;
    it.tag = tag;
    sb_q.push_back(it);
    model_carry = e ? 1'b1 : co;
  endtask

  task automatic idle(input string tag);
    @(posedge clk); #1;
    in_valid = 1'b0; in_bit = $urandom_range(0, 1);
    in_sop = $urandom_range(0, 1); in_eop = $urandom_range(0, 1);
  endtask

  // Sends an n-bit value LSB first with markers
  task automatic send_num(input int unsigned v, input int n, input bit use_sop, input string tag);
    for (int i = 0; i < n; i++)
      send(v[i], use_sop && (i == 0), i == n - 1, tag);
  endtask

  // Monitor: sample in the middle of the cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(out_valid == in_valid, "R7 valid mirror", out_valid, in_valid);
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R7 unexpected output", 1, 0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          chk(out_bit == it.exp_bit, it.tag, out_bit, it.exp_bit);
          chk(out_ovf == it.exp_ovf, {it.tag, " R8 ovf"}, out_ovf, it.exp_ovf);
        end
      end else begin
        chk(out_bit == 1'b0 && out_ovf == 1'b0, "R6 idle outputs", {out_bit, out_ovf}, 0);
      end
    end
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R7 reset state", out_valid, 0);
    rst = 1'b0;
    // R1: first bit after reset is incremented without a start marker
    send(1'b0, 1'b0, 1'b0, "R1 reset carry");
    send(1'b1, 1'b0, 1'b1, "R4 after R1");
    // R10 example, covers R2 R3 R4
    send_num(11, 4, 1'b1, "R10 example");
    // R8: all ones wraps with overflow
    send_num(15, 4, 1'b1, "R8 all ones");
    // R6: idle gaps inside a number
    send(1'b1, 1'b1, 1'b0, "R2 gap");
    idle("R6");
    send(1'b0, 1'b0, 1'b0, "R3 gap");
    idle("R6"); idle("R6");
    send(1'b1, 1'b0, 1'b1, "R4 gap");
    // R5: start marker while stored state is no-carry
    send(1'b0, 1'b1, 1'b0, "R3 pre");
    send(1'b1, 1'b1, 1'b0, "R5 sop forces");
    send(1'b1, 1'b0, 1'b1, "R5 tail");
    // R9: back to back numbers with no start marker
    send_num(7, 3, 1'b0, "R9 rearm");
    send_num(4, 3, 1'b0, "R9 rearm");
    send_num(1, 1, 1'b0, "R9 single");
    // Random streams
    for (int k = 0; k < 200; k++) begin
      int n = $urandom_range(1, 8);
      for (int i = 0; i < n; i++) begin
        if ($urandom_range(0, 3) == 0) idle("R6 random");
        send($urandom_range(0, 1), (i == 0) && $urandom_range(0, 1), i == n - 1, "R4 random");
      end
    end
    idle("R6");
    @(posedge clk); #3;
    chk(sb_q.size() == 0, "R7 drained", sb_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule